// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation structure held in ordinary memory. A client offers one request at a time: a virtual address plus a read/write flag. The walker samples the root-table base from a control input, reads a first-level entry, and then either stops there (a 4 MB large page) or reads a second-level entry (a 4 KB page). It owns a single memory port with one access outstanding at a time. It uses that port for the entry reads and for the write-backs that record use and modification.

Each walk ends in exactly one response cycle. Either `done` is high with the physical address, or `fault` is high with a cause code. On a fault the offending virtual address is kept in a register until the next fault, so a handler can read it later. Caching of translations is left to other logic.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle, and `busy` is high from the cycle after a request is accepted until the response cycle, inclusive. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R2: The first memory read of a walk is at `{base_cr[31:12], va[31:22], 2'b00}`. Bits [11:0] of `base_cr` do not affect any address. `base_cr` is sampled when the request is accepted.
- R3: When bit 7 of the first-level entry is clear, the second read is at `{pde[31:12], va[21:12], 2'b00}`, and the physical address is `{pte[31:12], va[11:0]}`.
- R4: When bit 7 of a present first-level entry is set, no second-level read is made. The physical address is `{pde[31:22], va[21:0]}`, and bits [21:12] of that entry are ignored.
- R5: An entry with bit 0 (present) clear ends the walk with `fault` and `fault_cause` = 1. No write-back is made to that entry or to any later one.
- R6: A write access that reaches a present entry with bit 1 (writable) clear, at either level, faults with `fault_cause` = 2. If the entry is also not present, cause 1 is reported instead.
- R7: Before the response, each entry visited on a walk that succeeds is written back with bit 5 (accessed) set, but only if that bit was clear. An entry that needs no change gets no write.
- R8: A successful write access also sets bit 6 (dirty) in the final entry: the second-level entry, or the first-level entry of a large page. The first-level entry of a 4 KB walk never has its dirty bit set by the walker.
- R9: `done` and `fault` are each high for exactly one cycle per walk and never together. `paddr` is valid while `done` is high.
- R10: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high.
- R11: `fault_addr` takes the virtual address of a faulting walk in the same cycle as `fault`, and it is unchanged at all other times. Its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_cr | input | 32 | Root-table base register; upper 20 bits used |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle success pulse |
| paddr | output | 32 | Translated physical address |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | 1 = not present, 2 = write to read-only |
| fault_addr | output | 32 | Virtual address of the latest fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
A wrong walk state shows up first on the memory port. An access with the wrong address or direction, or a missing or extra write-back, appears at the very access where it happens, and the bench compares every access against its expected list. A wrong decision on entry flags shows up no later than the response cycle, as a wrong pulse kind, cause, physical address or fault address. A state that fails to return to idle shows up within one cycle as a wrong `busy` or `req_ready` value, which is compared every clock.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_cr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_write,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] paddr,
  output logic          fault,
  output logic [1:0]    fault_cause,
  output logic [AW-1:0] fault_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata
);
  localparam int FRM = AW - 12;
  localparam int BP = 0, BW = 1, BA = 5, BD = 6, BL = 7;
  localparam logic [1:0] C_NP = 2'd1, C_RO = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_DRD, S_DWB, S_TRD, S_TWB, S_DONE, S_FLT} st_t;

  st_t st;
  logic [AW-1:0]  va_q, ent_q, pa_q, fa_q;
  logic [FRM-1:0] root_q, tbl_q;
  logic           wr_q, big_q;
  logic [1:0]     cause_q;

  wire rp = mem_rdata[BP];
  wire rw = mem_rdata[BW];
  wire [AW-1:0] acc_set = mem_rdata | (AW'(1) << BA);
  wire [AW-1:0] dty_set = acc_set | (AW'(1) << BD);
  wire [AW-1:0] last_upd = wr_q ? dty_set : acc_set;

  wire [AW-1:0] dir_addr = {root_q, va_q[31:22], 2'b00};
  wire [AW-1:0] tbl_addr = {tbl_q, va_q[21:12], 2'b00};

  assign req_ready = (st == S_IDLE);
  assign busy      = !req_ready;
  assign done      = (st == S_DONE);
  assign fault     = (st == S_FLT);
  assign paddr     = pa_q;
  assign fault_cause = cause_q;
  assign fault_addr  = fa_q;
  assign mem_req   = (st == S_DRD) || (st == S_DWB) || (st == S_TRD) || (st == S_TWB);
  assign mem_we    = (st == S_DWB) || (st == S_TWB);
  assign mem_addr  = (st == S_TRD || st == S_TWB) ? tbl_addr : dir_addr;
  assign mem_wdata = ent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      ent_q   <= '0;
      pa_q    <= '0;
      fa_q    <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      wr_q    <= 1'b0;
      big_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          root_q <= base_cr[AW-1:12];
          st     <= S_DRD;
        end
        S_DRD: if (mem_ack) begin
          if (!rp) begin
            cause_q <= C_NP;
            fa_q    <= va_q;
            st      <= S_FLT;
          end else if (wr_q && !rw) begin
            cause_q <= C_RO;
            fa_q    <= va_q;
            st      <= S_FLT;
          end else if (mem_rdata[BL]) begin
            big_q <= 1'b1;
            ent_q <= last_upd;
            pa_q  <= {mem_rdata[31:22], va_q[21:0]};
            st    <= (last_upd != mem_rdata) ? S_DWB : S_DONE;
          end else begin
            big_q <= 1'b0;
            ent_q <= acc_set;
            tbl_q <= mem_rdata[AW-1:12];
            st    <= mem_rdata[BA] ? S_TRD : S_DWB;
          end
        end
        S_DWB: if (mem_ack) st <= big_q ? S_DONE : S_TRD;
        S_TRD: if (mem_ack) begin
          if (!rp) begin
            cause_q <= C_NP;
            fa_q    <= va_q;
            st      <= S_FLT;
          end else if (wr_q && !rw) begin
            cause_q <= C_RO;
            fa_q    <= va_q;
            st      <= S_FLT;
          end else begin
            ent_q <= last_upd;
            pa_q  <= {mem_rdata[31:12], va_q[11:0]};
            st    <= (last_upd != mem_rdata) ? S_TWB : S_DONE;
          end
        end
        S_TWB: if (mem_ack) st <= S_DONE;
        S_DONE, S_FLT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_cause,
  input logic [31:0] fault_addr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !busy && !mem_req); // R1
  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R9
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |=> !(done || fault)); // R9
  AST_RESP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |=> req_ready); // R1
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R10
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> mem_wdata[5] && mem_wdata[0]); // R7
  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> (fault_cause == 2'd1 || fault_cause == 2'd2)); // R5
  AST_FADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fault |=> fault || $stable(fault_addr)); // R11
endmodule

bind pt_walker pt_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
  .fault(fault), .fault_cause(fault_cause), .fault_addr(fault_addr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_cr = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_ready, busy, done, fault, mem_req, mem_we;
  logic [31:0] paddr, fault_addr, mem_addr, mem_wdata;
  logic [1:0]  fault_cause;

  int compared = 0;
  int mismatched = 0;
  int lat = 0;
  int wait_cnt = 0;
  logic [31:0] last_fa = '0;

  logic [31:0] mem [logic [31:0]];
  logic        exp_we [$];
  logic [31:0] exp_addr [$];
  logic [31:0] exp_data [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .base_cr(base_cr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .busy(busy), .done(done), .paddr(paddr), .fault(fault), .fault_cause(fault_cause),
    .fault_addr(fault_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic void push(input logic we, input logic [31:0] a, input logic [31:0] d);
    exp_we.push_back(we);
    exp_addr.push_back(a);
    exp_data.push_back(d);
  endfunction

  // Behavioural model: walks the bench memory per the requirements
  function automatic void model(input logic [31:0] va, input logic wr, input logic [31:0] base,
                                output bit flt, output logic [1:0] cause, output logic [31:0] pa);
    logic [31:0] da, de, du, ta, te, tu;
    flt = 0; cause = 0; pa = 0;
    da = (base & 32'hFFFF_F000) + {20'h0, va[31:22], 2'b00};
    de = rd(da);
    push(0, da, 0);
    if (!de[0]) begin flt = 1; cause = 1; return; end
    if (wr && !de[1]) begin flt = 1; cause = 2; return; end
    if (de[7]) begin
      du = de | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (du != de) push(1, da, du);
      pa = {de[31:22], va[21:0]};
      return;
    end
    du = de | 32'h20;
    if (du != de) push(1, da, du);
    ta = (de & 32'hFFFF_F000) + {20'h0, va[21:12], 2'b00};
    te = rd(ta);
    push(0, ta, 0);
    if (!te[0]) begin flt = 1; cause = 1; return; end
    if (wr && !te[1]) begin flt = 1; cause = 2; return; end
    tu = te | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (tu != te) push(1, ta, tu);
    pa = {te[31:12], va[11:0]};
  endfunction

  // Memory responder: compares each access against the model's list (R2 R3 R7 R8 R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ack) begin
        mem_ack = 1'b0;
        wait_cnt = lat;
      end else if (mem_req) begin
        if (wait_cnt > 0) wait_cnt--;
        else begin
          if (exp_we.size() == 0) chk(0, "R7 unexpected memory access", mem_addr, 32'h0);
          else begin
            chk(mem_we == exp_we[0], "R7 access direction", {31'h0, mem_we}, {31'h0, exp_we[0]});
            chk(mem_addr == exp_addr[0], "R2 R3 entry address", mem_addr, exp_addr[0]);
            if (mem_we) chk(mem_wdata == exp_data[0], "R8 write-back data", mem_wdata, exp_data[0]);
            void'(exp_we.pop_front()); void'(exp_addr.pop_front()); void'(exp_data.pop_front());
          end
          if (mem_we) mem[mem_addr] = mem_wdata;
          else mem_rdata = rd(mem_addr);
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic xlate(input logic [31:0] va, input logic wr, input string tag);
    bit ef; logic [1:0] ec; logic [31:0] ep; bit seen;
    model(va, wr, base_cr, ef, ec, ep);
    if (ef) last_fa = va;
    wait_cnt = lat;
    chk(req_ready == 1'b1, {tag, " R1 ready idle"}, {31'h0, req_ready}, 32'h1);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = 32'hDEAD_BEEF;
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      chk(busy && !req_ready, {tag, " R1 busy"}, {30'h0, busy, req_ready}, 32'h2);
      if (done || fault) begin
        seen = 1;
        chk(fault == ef && done == !ef, {tag, " R9 response kind"}, {30'h0, done, fault}, {30'h0, !ef, ef});
        if (ef) chk(fault_cause == ec, {tag, " R5 R6 cause"}, {30'h0, fault_cause}, {30'h0, ec});
        else chk(paddr == ep, {tag, " R3 R4 paddr"}, paddr, ep);
        chk(fault_addr == last_fa, {tag, " R11 fault address"}, fault_addr, last_fa);
        chk(exp_we.size() == 0, {tag, " R7 all accesses made"}, exp_we.size(), 0);
      end else begin
        @(negedge clk);
      end
    end
    if (!seen) chk(0, {tag, " R9 no response"}, 0, 1);
    @(negedge clk);
    chk(!done && !fault && req_ready, {tag, " R9 single pulse"}, {29'h0, done, fault, req_ready}, 32'h1);
    exp_we.delete(); exp_addr.delete(); exp_data.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    base_cr = 32'h0001_0ABC;
    mem[32'h0001_0004] = 32'h0002_0003;
    mem[32'h0002_000C] = 32'h0055_5003;
    mem[32'h0001_00C0] = 32'h8003_F083;
    mem[32'h0001_0008] = 32'h0000_0000;
    mem[32'h0002_0010] = 32'h0000_0000;
    mem[32'h0002_0014] = 32'h0077_7021;
    mem[32'h0001_000C] = 32'h0003_0021;
    mem[32'h0003_0004] = 32'h0099_9003;
    mem[32'h0001_0010] = 32'h0000_0080;
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !done && !fault && !mem_req, "R1 reset outputs",
        {27'h0, req_ready, busy, done, fault, mem_req}, 32'h10);
    chk(fault_addr == 32'h0, "R11 reset fault address", fault_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    lat = 0; xlate(32'h0040_3123, 0, "R3 R7 4K first read");
    chk(mem[32'h0001_0004] == 32'h0002_0023, "R7 directory accessed", mem[32'h0001_0004], 32'h0002_0023);
    lat = 1; xlate(32'h0040_3FFF, 0, "R7 4K no write-back");
    lat = 2; xlate(32'h0040_3000, 1, "R8 4K write dirty");
    chk(mem[32'h0001_0004][6] == 1'b0, "R8 directory not dirty", mem[32'h0001_0004], 32'h0002_0023);
    chk(mem[32'h0002_000C] == 32'h0055_5063, "R8 table dirty", mem[32'h0002_000C], 32'h0055_5063);
    lat = 0; xlate(32'h0C12_3456, 0, "R4 large read");
    lat = 1; xlate(32'h0C3F_FFFF, 1, "R4 R8 large write");
    chk(mem[32'h0001_00C0] == 32'h8003_F0E3, "R8 large dirty", mem[32'h0001_00C0], 32'h8003_F0E3);
    lat = 0; xlate(32'h0080_0004, 0, "R5 directory not present");
    lat = 2; xlate(32'h0040_4008, 1, "R5 table not present");
    lat = 1; xlate(32'h0040_5010, 1, "R6 read-only table");
    chk(mem[32'h0002_0014] == 32'h0077_7021, "R5 no write on fault", mem[32'h0002_0014], 32'h0077_7021);
    lat = 0; xlate(32'h0040_5010, 0, "R6 read-only table read ok");
    lat = 1; xlate(32'h00C0_1000, 1, "R6 read-only directory");
    lat = 0; xlate(32'h00C0_1ABC, 0, "R11 success keeps fault address");
    lat = 2; xlate(32'h0100_0000, 1, "R6 not present wins");
    base_cr = 32'h0001_0FFF;
    lat = 0; xlate(32'h0040_3456, 0, "R2 base low bits ignored");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule